// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block sits on the path from a processor to memory and turns each virtual address into a physical one. It splits the address into two parts. The upper bits pick an entry in a small segment table held on chip, and the lower bits are the offset into that segment. Each table entry holds a base, a limit and a valid flag. The block adds the base to the offset to form the physical address. It flags an error when the entry is not valid, or when the offset lies at or beyond the limit.

Software loads the table through a configuration port, for example when the operating system switches context. A write is only accepted when the privilege qualifier is high. Translation requests arrive with a valid strobe. Each request gives exactly one registered response one clock later, carrying the physical address, an error flag and a cause code.

The default build has four segments selected by address bits 15:14. A parameter choice of three selector bits gives eight segments.

Top module: `seg_xlate`

## Requirements
- R1: With default parameters, virtual address bits 15:14 select the segment and bits 13:0 form the offset.
- R2: For an accepted access, rsp_pa equals the segment base plus the zero-extended offset, taken modulo 2^16. A sum that wraps past 0xFFFF is not an error.
- R3: If the offset is greater than or equal to the segment limit, the response has rsp_err=1, rsp_cause=2 and rsp_pa=0.
- R4: If the selected entry is not valid, the response has rsp_err=1, rsp_cause=1 and rsp_pa=0. This cause takes precedence over a limit violation.
- R5: After reset the table holds these entries:
  - segment 0: base 0x4000, limit 0x0800
  - segment 1: base 0x4800, limit 0x1400
  - segment 2: base 0xF000, limit 0x1000
  - segment 3: base 0x0000, limit 0x3000
  - all four entries are valid.
- R6: A write with cfg_wr_en=1 and cfg_priv=1 replaces the base, limit and valid flag of entry cfg_idx. A request in the same cycle still sees the old entry. Requests from the next cycle on see the new entry.
- R7: A write with cfg_priv=0 is rejected and leaves the table unchanged.
- R8: A request with req_vld=1 in cycle n gives rsp_vld=1 in cycle n+1. When req_vld=0, the next cycle shows rsp_vld=0 and rsp_pa, rsp_err and rsp_cause all 0. Back-to-back requests each get their own response.
- R9: A response without error has rsp_err=0 and rsp_cause=0.
- R10: With SEG_W=3 there are eight segments, selected by bits 15:13, with a 13-bit offset. Entries 0 to 3 reset as in R5, and entries 4 to 7 reset to not valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Translation request strobe |
| req_va | input | 16 | Virtual address |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Privilege qualifier for the write |
| cfg_idx | input | 2 | Entry index to write |
| cfg_base | input | 16 | New base |
| cfg_limit | input | 15 | New limit (offset must be below it) |
| cfg_valid | input | 1 | New valid flag |
| rsp_vld | output | 1 | Response strobe, one cycle after the request |
| rsp_pa | output | 16 | Physical address, 0 on error |
| rsp_err | output | 1 | Access error |
| rsp_cause | output | 2 | 0 none, 1 invalid segment, 2 limit violation |

## Verification
The translation is driven first with offsets at zero, at limit minus one, at the limit exactly, and at the top of the offset field, in every segment. This separates an off-by-one limit compare from a wrong selector split, and a wrong base from a missing add. Directed patterns then cover several cases:
- privileged and unprivileged writes, with and without a request in the same cycle, which separates write ordering from write gating;
- an invalid entry whose offset is also out of range, which fixes the cause priority;
- a base near the top of the space, which shows that wrap is not an error;
- back-to-back and idle cycles, which check the one-request, one-response timing.

A second instance with eight segments checks the wider selector.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_BADSEG = 2'd1,
      CAUSE_RANGE  = 2'd2
   } xl_cause_e;

   // Power-up table image; entries past the fourth come up unmapped
   function automatic logic [31:0] boot_base(input int idx);
      case (idx)
         0: boot_base = 32'h4000;
         1: boot_base = 32'h4800;
         2: boot_base = 32'hF000;
         default: boot_base = 32'h0000;
      endcase
   endfunction

   function automatic logic [31:0] boot_limit(input int idx);
      case (idx)
         0: boot_limit = 32'h0800;
         1: boot_limit = 32'h1400;
         2: boot_limit = 32'h1000;
         3: boot_limit = 32'h3000;
         default: boot_limit = 32'h0000;
      endcase
   endfunction

   function automatic logic boot_valid(input int idx);
      boot_valid = (idx < 4);
   endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W = 2,
   parameter int PA_W  = 16,
   parameter int LIM_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_priv,
   input  logic [SEG_W-1:0] wr_idx,
   input  logic [PA_W-1:0]  wr_base,
   input  logic [LIM_W-1:0] wr_limit,
   input  logic             wr_valid,
   input  logic [SEG_W-1:0] rd_idx,
   output logic [PA_W-1:0]  rd_base,
   output logic [LIM_W-1:0] rd_limit,
   output logic             rd_valid
);

   localparam int NSEG  = 1 << SEG_W;
   localparam int ENT_W = PA_W + LIM_W + 1;

   initial begin
      assert (SEG_W >= 1 && SEG_W <= 4) else $error("seg_table: SEG_W out of range");
      assert (PA_W >= 8) else $error("seg_table: PA_W too small");
   end

   logic [PA_W-1:0]       base_q  [NSEG];
   logic [LIM_W-1:0]      limit_q [NSEG];
   logic [NSEG-1:0]       valid_q;
   logic [NSEG*ENT_W-1:0] tbl_flat;

   // Only a qualified write may land
   logic wr_ok;
   assign wr_ok = wr_en && wr_priv;

   for (genvar g = 0; g < NSEG; g++) begin : g_ent
      logic [PA_W-1:0]  rst_b;
      logic [LIM_W-1:0] rst_l;
      logic             rst_v;
      if (g < 4) begin : g_preset
         assign rst_b = PA_W'(boot_base(g));
         assign rst_l = LIM_W'(boot_limit(g));
         assign rst_v = boot_valid(g);
      end else begin : g_blank
         assign rst_b = '0;
         assign rst_l = '0;
         assign rst_v = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[g]  <= rst_b;
            limit_q[g] <= rst_l;
            valid_q[g] <= rst_v;
         end else if (wr_ok && (wr_idx == SEG_W'(g))) begin
            base_q[g]  <= wr_base;
            limit_q[g] <= wr_limit;
            valid_q[g] <= wr_valid;
         end
      end

      assign tbl_flat[g*ENT_W +: ENT_W] = {valid_q[g], limit_q[g], base_q[g]};
   end

   assign rd_base  = base_q[rd_idx];
   assign rd_limit = limit_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];

   // R7: an unprivileged write leaves every entry untouched
   p_user_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_priv) |=> $stable(tbl_flat));

   // R6: a privileged write is visible through the read port on the next cycle
   p_priv_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && rd_idx == wr_idx) |=> (rd_idx != $past(wr_idx)) ||
         (rd_base == $past(wr_base) && rd_limit == $past(wr_limit) && rd_valid == $past(wr_valid)));

endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int OFF_W = 14,
   parameter int PA_W  = 16,
   parameter int LIM_W = 15
) (
   input  logic [OFF_W-1:0] offset,
   input  logic [PA_W-1:0]  base,
   input  logic [LIM_W-1:0] limit,
   input  logic             ent_valid,
   output logic [PA_W-1:0]  phys,
   output xl_cause_e        cause
);

   initial begin
      assert (LIM_W == OFF_W + 1) else $error("seg_check: LIM_W must be OFF_W+1");
      assert (PA_W >= OFF_W) else $error("seg_check: PA_W narrower than offset");
   end

   logic [LIM_W-1:0] off_ext;
   logic             over;
   logic [PA_W-1:0]  sum;

   assign off_ext = {1'b0, offset};
   assign over    = (off_ext >= limit);
   assign sum     = base + PA_W'(offset);   // wraps modulo 2^PA_W

   always_comb begin
      if (!ent_valid) begin
         cause = CAUSE_BADSEG;
         phys  = '0;
      end else if (over) begin
         cause = CAUSE_RANGE;
         phys  = '0;
      end else begin
         cause = CAUSE_NONE;
         phys  = sum;
      end
   end

endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg
   import seg_xlate_pkg::*;
#(
   parameter int PA_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic [PA_W-1:0] in_pa,
   input  xl_cause_e       in_cause,
   output logic            out_vld,
   output logic [PA_W-1:0] out_pa,
   output logic            out_err,
   output logic [1:0]      out_cause
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld   <= 1'b0;
         out_pa    <= '0;
         out_err   <= 1'b0;
         out_cause <= 2'd0;
      end else if (in_vld) begin
         out_vld   <= 1'b1;
         out_pa    <= in_pa;
         out_err   <= (in_cause != CAUSE_NONE);
         out_cause <= in_cause;
      end else begin
         out_vld   <= 1'b0;
         out_pa    <= '0;
         out_err   <= 1'b0;
         out_cause <= 2'd0;
      end
   end

   // R8: one response per request, exactly one cycle later
   p_resp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && out_pa == '0 && !out_err));

   // R3 / R4: an error response never carries a usable address
   p_err_pa_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_pa == '0));

   // R9: the error flag and cause code agree
   p_cause_agrees_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_err == (out_cause != 2'd0)));

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int VA_W  = 16,
   parameter int SEG_W = 2,
   parameter int PA_W  = 16,
   localparam int OFF_W = VA_W - SEG_W,
   localparam int LIM_W = OFF_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_vld,
   input  logic [VA_W-1:0]  req_va,
   input  logic             cfg_wr_en,
   input  logic             cfg_priv,
   input  logic [SEG_W-1:0] cfg_idx,
   input  logic [PA_W-1:0]  cfg_base,
   input  logic [LIM_W-1:0] cfg_limit,
   input  logic             cfg_valid,
   output logic             rsp_vld,
   output logic [PA_W-1:0]  rsp_pa,
   output logic             rsp_err,
   output logic [1:0]       rsp_cause
);

   initial begin
      assert (VA_W > SEG_W + 1) else $error("seg_xlate: VA_W too narrow for selector");
      assert (SEG_W == 2 || SEG_W == 3) else $error("seg_xlate: SEG_W must be 2 or 3");
   end

   logic [SEG_W-1:0] seg_sel;
   logic [OFF_W-1:0] seg_off;
   logic [PA_W-1:0]  ent_base;
   logic [LIM_W-1:0] ent_limit;
   logic             ent_valid;
   logic [PA_W-1:0]  xl_pa;
   xl_cause_e        xl_cause;

   assign seg_sel = req_va[VA_W-1 -: SEG_W];
   assign seg_off = req_va[OFF_W-1:0];

   seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr_en),
      .wr_priv  (cfg_priv),
      .wr_idx   (cfg_idx),
      .wr_base  (cfg_base),
      .wr_limit (cfg_limit),
      .wr_valid (cfg_valid),
      .rd_idx   (seg_sel),
      .rd_base  (ent_base),
      .rd_limit (ent_limit),
      .rd_valid (ent_valid)
   );

   seg_check #(.OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_check (
      .offset    (seg_off),
      .base      (ent_base),
      .limit     (ent_limit),
      .ent_valid (ent_valid),
      .phys      (xl_pa),
      .cause     (xl_cause)
   );

   seg_resp_reg #(.PA_W(PA_W)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (req_vld),
      .in_pa     (xl_pa),
      .in_cause  (xl_cause),
      .out_vld   (rsp_vld),
      .out_pa    (rsp_pa),
      .out_err   (rsp_err),
      .out_cause (rsp_cause)
   );

   // R4: an unmapped entry reports cause 1, ahead of any range check
   p_badseg_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !ent_valid) |=> (rsp_err && rsp_cause == 2'd1));

   // R3: offset at or past the limit of a mapped entry reports cause 2
   p_range_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && ent_valid && ({1'b0, seg_off} >= ent_limit)) |=> (rsp_err && rsp_cause == 2'd2));

   // R2: an in-range access to a mapped entry is never flagged, even if it wraps
   p_inrange_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && ent_valid && ({1'b0, seg_off} < ent_limit)) |=> (!rsp_err && rsp_cause == 2'd0));

endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [15:0] req_va = '0;
   logic        cfg_wr_en = 1'b0, cfg_priv = 1'b0, cfg_valid = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [15:0] cfg_base = '0;
   logic [14:0] cfg_limit = '0;
   logic        rsp_vld, rsp_err;
   logic [15:0] rsp_pa;
   logic [1:0]  rsp_cause;

   // eight-segment variant
   logic        req8_vld = 1'b0;
   logic [15:0] req8_va = '0;
   logic        rsp8_vld, rsp8_err;
   logic [15:0] rsp8_pa;
   logic [1:0]  rsp8_cause;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;   // 100 MHz

   seg_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_va(req_va),
      .cfg_wr_en(cfg_wr_en), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
      .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
      .rsp_vld(rsp_vld), .rsp_pa(rsp_pa), .rsp_err(rsp_err), .rsp_cause(rsp_cause)
   );

   seg_xlate #(.SEG_W(3)) u_dut8 (
      .clk(clk), .rst_n(rst_n), .req_vld(req8_vld), .req_va(req8_va),
      .cfg_wr_en(1'b0), .cfg_priv(1'b0), .cfg_idx(3'd0),
      .cfg_base(16'd0), .cfg_limit(14'd0), .cfg_valid(1'b0),
      .rsp_vld(rsp8_vld), .rsp_pa(rsp8_pa), .rsp_err(rsp8_err), .rsp_cause(rsp8_cause)
   );

   localparam int NV = 12;
   localparam logic [15:0] V_VA [NV] = '{16'h0000, 16'h07FF, 16'h0800, 16'h4000,
                                         16'h53FF, 16'h5400, 16'h8FFF, 16'h9000,
                                         16'hC000, 16'hEFFF, 16'hF000, 16'hFFFF};
   localparam logic [15:0] V_PA [NV] = '{16'h4000, 16'h47FF, 16'h0000, 16'h4800,
                                         16'h5BFF, 16'h0000, 16'hFFFF, 16'h0000,
                                         16'h0000, 16'h2FFF, 16'h0000, 16'h0000};
   localparam logic [1:0]  V_CS [NV] = '{2'd0, 2'd0, 2'd2, 2'd0,
                                         2'd0, 2'd2, 2'd0, 2'd2,
                                         2'd0, 2'd0, 2'd2, 2'd2};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // checks the response that is visible now (sampled at a falling edge)
   task automatic chk_rsp(input string tag, input logic [15:0] pa, input logic [1:0] cs);
      chk({tag, " vld"}, {31'd0, rsp_vld}, 32'd1);
      chk({tag, " pa"}, {16'd0, rsp_pa}, {16'd0, pa});
      chk({tag, " err"}, {31'd0, rsp_err}, {31'd0, (cs != 2'd0)});
      chk({tag, " cause"}, {30'd0, rsp_cause}, {30'd0, cs});
   endtask

   task automatic xlate(input string tag, input logic [15:0] va,
                        input logic [15:0] pa, input logic [1:0] cs);
      req_vld = 1'b1;
      req_va  = va;
      @(negedge clk);
      req_vld = 1'b0;
      chk_rsp(tag, pa, cs);
   endtask

   task automatic cfg_write(input logic priv, input logic [1:0] idx, input logic [15:0] b,
                            input logic [14:0] l, input logic v);
      cfg_wr_en = 1'b1; cfg_priv = priv; cfg_idx = idx;
      cfg_base = b; cfg_limit = l; cfg_valid = v;
      @(negedge clk);
      cfg_wr_en = 1'b0; cfg_priv = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state (R8)
      chk("R8 reset rsp_vld", {31'd0, rsp_vld}, 32'd0);
      chk("R8 reset rsp_err", {31'd0, rsp_err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R5 R9: vector walk over the power-up table
      for (int i = 0; i < NV; i++) begin
         xlate($sformatf("R5 R1 R3 R9 vec%0d", i), V_VA[i], V_PA[i], V_CS[i]);
      end

      // R8: idle cycle after a request
      @(negedge clk);
      chk("R8 idle rsp_vld", {31'd0, rsp_vld}, 32'd0);
      chk("R8 idle rsp_pa", {16'd0, rsp_pa}, 32'd0);

      // R8: back-to-back requests
      req_vld = 1'b1; req_va = 16'h0010;
      @(negedge clk);
      chk_rsp("R8 b2b first", 16'h4010, 2'd0);
      req_va = 16'h4020;
      @(negedge clk);
      req_vld = 1'b0;
      chk_rsp("R8 b2b second", 16'h4820, 2'd0);

      // R7: unprivileged write rejected
      cfg_write(1'b0, 2'd0, 16'h1234, 15'h0001, 1'b0);
      xlate("R7 user write ignored", 16'h0000, 16'h4000, 2'd0);

      // R6: privileged write; same-cycle request sees the old entry
      cfg_wr_en = 1'b1; cfg_priv = 1'b1; cfg_idx = 2'd0;
      cfg_base = 16'h1000; cfg_limit = 15'h0100; cfg_valid = 1'b1;
      req_vld = 1'b1; req_va = 16'h0000;
      @(negedge clk);
      cfg_wr_en = 1'b0; cfg_priv = 1'b0; req_vld = 1'b0;
      chk_rsp("R6 same-cycle old entry", 16'h4000, 2'd0);
      xlate("R6 new base", 16'h0040, 16'h1040, 2'd0);
      xlate("R6 new limit R3", 16'h0100, 16'h0000, 2'd2);

      // R4: invalidated entry, including precedence over range
      cfg_write(1'b1, 2'd3, 16'h0000, 15'h3000, 1'b0);
      xlate("R4 invalid in range", 16'hC000, 16'h0000, 2'd1);
      xlate("R4 invalid beyond limit", 16'hFFFF, 16'h0000, 2'd1);

      // R2: wrap modulo 2^16 is not an error
      cfg_write(1'b1, 2'd2, 16'hFFF0, 15'h0100, 1'b1);
      xlate("R2 wrap", 16'h8020, 16'h0010, 2'd0);

      // R10: eight-segment variant, selector bits 15:13
      req8_vld = 1'b1; req8_va = 16'h2100;   // seg 1, offset 0x100
      @(negedge clk);
      chk("R10 seg1 pa", {16'd0, rsp8_pa}, 32'h4900);
      chk("R10 seg1 cause", {30'd0, rsp8_cause}, 32'd0);
      req8_va = 16'hA000;                    // seg 5, unmapped
      @(negedge clk);
      req8_vld = 1'b0;
      chk("R10 seg5 vld", {31'd0, rsp8_vld}, 32'd1);
      chk("R10 seg5 cause", {30'd0, rsp8_cause}, 32'd1);
      chk("R10 seg5 pa", {16'd0, rsp8_pa}, 32'd0);

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule